// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block carries out the seven single-operand bit-movement operations of a small integer datapath on an 8-bit or 16-bit value: logical shift left, logical shift right, arithmetic shift right, rotate left, rotate right, and left and right rotates that pass through the carry flag. The caller presents an operand, a width select, an operation code, a step count and the incoming carry. It then pulses a start strobe. The unit moves the value one bit position per clock until the count is used up. It then raises a one-cycle completion pulse, with the new value and the new carry held steady on its outputs.

In the through-carry rotates, the carry flag is one more bit of the rotating ring, so the ring is 9 or 17 bits long. The arithmetic right shift keeps the sign bit. The width is chosen for each request, not at build time. Flags other than the carry are computed elsewhere.

Top module: `shrot_unit`

## Requirements
- R1: Code 0 (shift left) moves every bit one place toward the MSB on each step and puts a zero in bit 0. The carry takes the bit that left the MSB position, which is bit 15 in word mode and bit 7 in byte mode.
- R2: Code 1 (logical shift right) moves every bit one place toward bit 0 on each step and puts a zero in the MSB position. The carry takes the bit that left bit 0.
- R3: Code 2 (arithmetic shift right) moves every bit toward bit 0 on each step, copies the old MSB back into the MSB, and puts the bit that left bit 0 into the carry.
- R4: Code 3 (rotate left) puts the old MSB into both bit 0 and the carry on each step.
- R5: Code 4 (rotate right) puts the old bit 0 into both the MSB and the carry on each step.
- R6: Code 5 (rotate left through carry) puts the old MSB into the carry and the old carry into bit 0 on each step. After 9 steps (byte) or 17 steps (word), the operand and carry are back where they started.
- R7: Code 6 (rotate right through carry) puts the old bit 0 into the carry and the old carry into the MSB on each step. The ring is 9 or 17 bits long, as in R6.
- R8: `wide_i` = 1 selects word mode and `wide_i` = 0 selects byte mode. In byte mode only operand bits 7..0 take part, bit 7 acts as the MSB, and result bits 15..8 are zero.
- R9: With a count of n, `done_o` goes high n rising edges after the edge that captures `start_i`, or on that same edge when n = 0. It stays high for exactly one cycle.
- R10: A count of zero returns the operand (byte-masked in byte mode) as the result and `carry_i` as the carry.
- R11: A start is accepted only while the unit is idle, which is neither stepping nor showing `done_o`. A start at any other time has no effect on the running request. The result and carry stay unchanged after `done_o` until the next accepted start.
- R12: Code 7 is reserved. Each of its steps leaves the value and carry unchanged, but its timing follows R9.
- R13: While `rst_n` is low, `result_o` and `carry_o` read zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled on the rising edge |
| op_i | input | 3 | Operation code (0..6 as in R1..R7, 7 reserved) |
| wide_i | input | 1 | 1 = 16-bit word, 0 = 8-bit byte |
| operand_i | input | 16 | Value to shift or rotate |
| count_i | input | 5 | Number of one-bit steps |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 16 | Shifted or rotated value |
| carry_o | output | 1 | New carry flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default widths: a 16-bit word, an 8-bit byte and a 5-bit count. A count of up to 31 covers several cases. It lets the bench run a full 17-step word ring and a full 9-step byte ring through the carry, and confirm that the start state comes back. It also lets the bench shift a whole word or byte out so that only the last bit leaving lands in the carry. For every vector the bench measures the completion latency in clock edges. It also checks busy-time starts, result holding and reset in the middle of a request.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_RSV = 3'd7
    } shrot_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } shrot_state_e;

endpackage

// File: rtl/shrot_step.sv
module shrot_step
    import shrot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic              cf_i,
    input  shrot_op_e         op_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] val_o,
    output logic              cf_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] WORD_MSB = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] BYTE_MSB = IDX_W'(BYTE_W - 1);

    logic [DATA_W-1:0] keep_mask;
    logic [IDX_W-1:0]  msb_idx;
    logic              top_bit;
    logic              low_bit;
    logic [DATA_W-1:0] raw;

    // one mask bit per position: upper lanes live only in word mode
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        if (b < BYTE_W) begin : g_low
            assign keep_mask[b] = 1'b1;
        end else begin : g_high
            assign keep_mask[b] = wide_i;
        end
    end

    assign msb_idx = wide_i ? WORD_MSB : BYTE_MSB;
    assign top_bit = val_i[msb_idx];
    assign low_bit = val_i[0];

    always_comb begin
        raw  = val_i;
        cf_o = cf_i;
        unique case (op_i)
            OP_SHL: begin
                raw  = val_i << 1;
                cf_o = top_bit;
            end
            OP_SHR: begin
                raw          = val_i >> 1;
                raw[msb_idx] = 1'b0;
                cf_o         = low_bit;
            end
            OP_SAR: begin
                raw          = val_i >> 1;
                raw[msb_idx] = top_bit;
                cf_o         = low_bit;
            end
            OP_ROL: begin
                raw    = val_i << 1;
                raw[0] = top_bit;
                cf_o   = top_bit;
            end
            OP_ROR: begin
                raw          = val_i >> 1;
                raw[msb_idx] = low_bit;
                cf_o         = low_bit;
            end
            OP_RCL: begin
                raw    = val_i << 1;
                raw[0] = cf_i;
                cf_o   = top_bit;
            end
            OP_RCR: begin
                raw          = val_i >> 1;
                raw[msb_idx] = cf_i;
                cf_o         = low_bit;
            end
            OP_RSV: begin
                raw  = val_i;
                cf_o = cf_i;
            end
            default: begin
                raw  = val_i;
                cf_o = cf_i;
            end
        endcase
        val_o = raw & keep_mask;
    end

endmodule

// File: rtl/shrot_counter.sv
module shrot_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= load_val_i;
        end else if (dec_i && left_q != '0) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign last_o = (left_q == CNT_W'(1));

    // R9: each stepping cycle removes exactly one step from the budget
    a_r9_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && left_q != '0) |=> left_q == $past(left_q) - CNT_W'(1));

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              done_o
);
    localparam logic [DATA_W-1:0] BYTE_MASK =
        {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    shrot_state_e      state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              cf_q;
    shrot_op_e         op_q;
    logic              wide_q;

    logic              accept;
    logic              stepping;
    logic              last_step;
    logic [DATA_W-1:0] step_val;
    logic              step_cf;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign stepping = (state_q == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: IDLE->RUN, IDLE->DONE (zero count), RUN->DONE, DONE->IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (count_i == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (last_step) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // request capture and the working value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cf_q   <= 1'b0;
            op_q   <= OP_SHL;
            wide_q <= 1'b0;
        end else if (accept) begin
            data_q <= wide_i ? operand_i : (operand_i & BYTE_MASK);
            cf_q   <= carry_i;
            op_q   <= shrot_op_e'(op_i);
            wide_q <= wide_i;
        end else if (stepping) begin
            data_q <= step_val;
            cf_q   <= step_cf;
        end
    end

    // outputs
    always_comb begin
        result_o = data_q;
        carry_o  = cf_q;
        done_o   = (state_q == ST_DONE);
    end

    shrot_step #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) step_i (
        .val_i  (data_q),
        .cf_i   (cf_q),
        .op_i   (op_q),
        .wide_i (wide_q),
        .val_o  (step_val),
        .cf_o   (step_cf)
    );

    shrot_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (count_i),
        .dec_i      (stepping),
        .last_o     (last_step)
    );

    // R9: completion lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: byte results never carry upper bits
    a_r8_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |-> result_o[DATA_W-1:BYTE_W] == '0);

    // R4: plain rotates neither create nor lose ones
    a_r4_rotate_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && (op_q == OP_ROL || op_q == OP_ROR))
        |=> $countones(data_q) == $past($countones(data_q)));

    // R6: the carry ring keeps its population
    a_r6_ring_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && (op_q == OP_RCL || op_q == OP_RCR))
        |=> $countones({cf_q, data_q}) == $past($countones({cf_q, data_q})));

    // R3: sign bit is never disturbed in a word arithmetic shift
    a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && op_q == OP_SAR && wide_q)
        |=> data_q[DATA_W-1] == $past(data_q[DATA_W-1]));

    // R10: zero count completes at once with the incoming carry
    a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && count_i == '0)
        |=> done_o && carry_o == $past(carry_i));

    // R11: a busy unit keeps its captured request
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (op_q == $past(op_q) && wide_q == $past(wide_q)));

endmodule

// File: tb/shrot_unit_tb_top.sv
module shrot_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 21;
    localparam int WAIT_LIMIT = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic [15:0] operand_i = '0;
    logic [4:0]  count_i = '0;
    logic        carry_i = 1'b0;
    logic [15:0] result_o;
    logic        carry_o;
    logic        done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shrot_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .wide_i    (wide_i),
        .operand_i (operand_i),
        .count_i   (count_i),
        .carry_i   (carry_i),
        .result_o  (result_o),
        .carry_o   (carry_o),
        .done_o    (done_o)
    );

    // {op, wide, operand, count, carry in, expected result, expected carry}
    localparam logic [42:0] VEC [NVEC] = '{
        {3'd0, 1'b1, 16'h8001, 5'd1,  1'b0, 16'h0002, 1'b1},
        {3'd0, 1'b0, 16'hABC3, 5'd2,  1'b0, 16'h000C, 1'b1},
        {3'd1, 1'b1, 16'h0003, 5'd1,  1'b0, 16'h0001, 1'b1},
        {3'd1, 1'b1, 16'h8000, 5'd3,  1'b1, 16'h1000, 1'b0},
        {3'd2, 1'b1, 16'h8004, 5'd2,  1'b0, 16'hE001, 1'b0},
        {3'd2, 1'b0, 16'h0081, 5'd1,  1'b0, 16'h00C0, 1'b1},
        {3'd3, 1'b1, 16'h8001, 5'd1,  1'b0, 16'h0003, 1'b1},
        {3'd3, 1'b0, 16'h1281, 5'd1,  1'b0, 16'h0003, 1'b1},
        {3'd4, 1'b1, 16'h0001, 5'd4,  1'b0, 16'h1000, 1'b0},
        {3'd4, 1'b0, 16'h0001, 5'd1,  1'b0, 16'h0080, 1'b1},
        {3'd5, 1'b1, 16'h8000, 5'd1,  1'b1, 16'h0001, 1'b1},
        {3'd5, 1'b1, 16'h8000, 5'd2,  1'b0, 16'h0001, 1'b0},
        {3'd5, 1'b0, 16'h0080, 5'd9,  1'b0, 16'h0080, 1'b0},
        {3'd6, 1'b1, 16'h0001, 5'd1,  1'b0, 16'h0000, 1'b1},
        {3'd6, 1'b0, 16'h0000, 5'd1,  1'b1, 16'h0080, 1'b0},
        {3'd6, 1'b1, 16'h0000, 5'd17, 1'b1, 16'h0000, 1'b1},
        {3'd0, 1'b1, 16'h1234, 5'd0,  1'b1, 16'h1234, 1'b1},
        {3'd0, 1'b0, 16'hFF55, 5'd0,  1'b0, 16'h0055, 1'b0},
        {3'd7, 1'b1, 16'hBEEF, 5'd3,  1'b1, 16'hBEEF, 1'b1},
        {3'd0, 1'b1, 16'hFFFF, 5'd16, 1'b0, 16'h0000, 1'b1},
        {3'd1, 1'b0, 16'h0080, 5'd8,  1'b0, 16'h0000, 1'b1}
    };

    function automatic string tag_of(input logic [2:0] op, input logic [4:0] cnt,
                                     input logic wide);
        string t;
        case (op)
            3'd0: t = "R1";
            3'd1: t = "R2";
            3'd2: t = "R3";
            3'd3: t = "R4";
            3'd4: t = "R5";
            3'd5: t = "R6";
            3'd6: t = "R7";
            default: t = "R12";
        endcase
        if (cnt == 0) t = {t, "/R10"};
        if (!wide) t = {t, "/R8"};
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // start a request, return latency in edges after the capture edge
    task automatic run_op(input logic [2:0] op, input logic wide, input logic [15:0] opnd,
                          input logic [4:0] cnt, input logic cin, output int lat);
        @(negedge clk);
        start_i   = 1'b1;
        op_i      = op;
        wide_i    = wide;
        operand_i = opnd;
        count_i   = cnt;
        carry_i   = cin;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < WAIT_LIMIT) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R13: reset state
        check(result_o == 16'h0, "R13", "reset result", 32'(result_o), 32'h0);
        check(carry_o == 1'b0 && done_o == 1'b0, "R13", "reset carry/done",
              {30'd0, carry_o, done_o}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [42:0] v;
            string t;
            v = VEC[i];
            t = tag_of(v[42:40], v[22:18], v[39]);
            run_op(v[42:40], v[39], v[38:23], v[22:18], v[17], lat);
            check(lat == int'(v[22:18]), {t, "/R9"}, $sformatf("latency vec %0d", i),
                  32'(lat), 32'(v[22:18]));
            check(result_o == v[16:1], t, $sformatf("result vec %0d", i),
                  32'(result_o), 32'(v[16:1]));
            check(carry_o == v[0], t, $sformatf("carry vec %0d", i),
                  32'(carry_o), 32'(v[0]));
            @(negedge clk);
            check(done_o == 1'b0, "R9", $sformatf("done width vec %0d", i),
                  32'(done_o), 32'h0);
        end

        // R11: start while stepping is ignored
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd0; wide_i = 1'b1; operand_i = 16'h0001;
        count_i = 5'd4; carry_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        op_i = 3'd1; operand_i = 16'hFFFF; count_i = 5'd0; carry_i = 1'b1;
        lat = 0;
        while (!done_o && lat < WAIT_LIMIT) begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        check(lat == 4, "R11", "busy start latency", 32'(lat), 32'd4);
        check(result_o == 16'h0010 && carry_o == 1'b0, "R11", "busy start result",
              {15'd0, carry_o, result_o}, 32'h0000_0010);

        // R11: result held after completion
        held = result_o;
        repeat (4) @(negedge clk);
        check(result_o == held && carry_o == 1'b0 && done_o == 1'b0, "R11",
              "hold after done", {15'd0, carry_o, result_o}, {16'd0, held});

        // R13: reset in the middle of a request
        run_op(3'd3, 1'b1, 16'hF0F0, 5'd20, 1'b1, lat);
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd4; count_i = 5'd20; operand_i = 16'h1234;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(result_o == 16'h0 && carry_o == 1'b0 && done_o == 1'b0, "R13",
              "mid-run reset", {14'd0, carry_o, done_o, result_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 / R10 after reset: byte zero-count masks upper byte
        run_op(3'd2, 1'b0, 16'h80FF, 5'd0, 1'b1, lat);
        check(result_o == 16'h00FF && carry_o == 1'b1, "R10", "post-reset zero count",
              {15'd0, carry_o, result_o}, 32'h0001_00FF);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule